// File: doc/BRIEF.md
# VLAN Membership Table Command Engine

This block keeps a small table that maps 12-bit VLAN identifiers to a member port mask. Software never writes table entries directly. It first places a mask and a valid flag in a data register. It then writes a command word that holds an opcode, a VLAN identifier, a port number and a go bit. The engine carries out the command over several clock cycles and visits one table entry per cycle. While it works it reports busy through the go bit, which reads back as 1. A load that finds neither a matching entry nor a free entry raises a full flag.

The command set has five members. A whole-table flush invalidates every entry. A load adds an entry or overwrites an existing one. A purge invalidates one identifier. A remove-port command clears one port bit from every valid entry. A no-op completes at once. A separate combinational lookup port returns the member mask and a hit flag for any identifier at any time, and forwarding logic elsewhere uses it.

Top module: `vlan_tbl_engine`

## Requirements
- R1: After reset every table entry is invalid, the command word reads back as zero (busy = 0, full = 0), and every lookup misses.
- R2: The command word (select 0) has the opcode in bits [2:0] (0 no-op, 1 flush, 2 load, 3 purge, 4 remove port; 5 to 7 act as no-op), go/busy in bit 3, full in bit 4 (read-only), the port in bits [11:8] and the VLAN identifier in bits [27:16]. The data word (select 1) has the mask in bits [9:0] and the valid flag in bit 11. Both words read back these fields, with all other bits zero.
- R3: A command write with bit 3 set starts the command, and bit 3 reads 1 until the command ends. A command write with bit 3 clear only stores the fields: nothing runs and the table does not change.
- R4: A load whose identifier matches no valid entry stores the data-register mask and valid flag in the lowest-index invalid entry. A load keeps busy set for 17 cycles.
- R5: A load whose identifier matches a valid entry overwrites that entry, even when the table has no free entry.
- R6: A load that finds neither a match nor a free entry sets full and leaves the table unchanged. Full is cleared when the next command starts.
- R7: A purge invalidates the valid entry that holds the given identifier and leaves all other entries unchanged.
- R8: A remove-port command clears the given port's bit in every valid entry, and an entry whose mask becomes zero stays valid.
- R9: A flush invalidates all 16 entries, one per cycle, and keeps busy set for 16 cycles.
- R10: While busy, writes to the command word and to the data word are ignored.
- R11: A lookup with no valid matching entry returns hit = 0 and mask = 0. A lookup with a matching entry returns hit = 1 and that entry's mask.
- R12: A no-op command keeps busy set for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 command word, 1 data word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| lk_vid | input | 12 | Lookup VLAN identifier |
| lk_hit | output | 1 | Lookup found a valid entry |
| lk_mask | output | 10 | Member mask of the matching entry, zero on a miss |

## Verification
The main function runs through a table of command vectors. Each vector is followed by a lookup. Together they separate three cases: a fresh load into a free slot, an overwrite of a live identifier, and a purge, which must turn a hit into a miss. Remove-port vectors on a low port and on the top port show the difference between clearing one bit and clearing the whole mask while the entry stays valid. The identifiers include 4095, the top of the range. A fill-to-capacity sequence shows that an overwrite still succeeds while the table is full and that a fresh identifier raises full. Busy-length counts separate the 1-cycle no-op, the 16-cycle flush and the 17-cycle load. Writes issued during busy show that command fields and data are locked.

// File: rtl/vlan_tbl_pkg.sv
package vlan_tbl_pkg;
    localparam int VID_W  = 12;
    localparam int MASK_W = 10;
    localparam int PORT_W = 4;

    // register field positions decoded by software
    localparam int CMD_GO_BIT    = 3;
    localparam int CMD_FULL_BIT  = 4;
    localparam int CMD_PORT_LSB  = 8;
    localparam int CMD_VID_LSB   = 16;
    localparam int DAT_VALID_BIT = 11;

    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_FLUSH     = 3'd1,
        OP_LOAD      = 3'd2,
        OP_PURGE     = 3'd3,
        OP_DROP_PORT = 3'd4
    } op_e;

    typedef struct packed {
        logic              valid;
        logic [VID_W-1:0]  vid;
        logic [MASK_W-1:0] mask;
    } vlan_ent_t;
endpackage

// File: rtl/vlan_tbl_store.sv
module vlan_tbl_store
    import vlan_tbl_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  vlan_ent_t               wr_ent,
    output vlan_ent_t [DEPTH-1:0]   tbl_o
);
    vlan_ent_t [DEPTH-1:0] tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) tbl_d[wr_idx] = wr_ent;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign tbl_o = tbl_q;
endmodule

// File: rtl/vlan_tbl_lookup.sv
module vlan_tbl_lookup
    import vlan_tbl_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  vlan_ent_t [DEPTH-1:0] tbl,
    input  logic [VID_W-1:0]      q_vid,
    output logic                  hit,
    output logic [MASK_W-1:0]     mask
);
    logic [DEPTH-1:0] match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = tbl[g].valid && (tbl[g].vid == q_vid);
    end

    always_comb begin
        hit  = 1'b0;
        mask = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit  = 1'b1;
                mask = tbl[i].mask;
            end
        end
    end

    // R5: loads overwrite live identifiers, so no identifier is stored twice
    p_unique_vid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R11: a miss never carries a mask
    p_miss_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (mask == '0));
endmodule

// File: rtl/vlan_tbl_ctrl.sv
module vlan_tbl_ctrl
    import vlan_tbl_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic                  reg_sel,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  vlan_ent_t [DEPTH-1:0] tbl,
    output logic                  wr_en,
    output logic [IDX_W-1:0]      wr_idx,
    output vlan_ent_t             wr_ent,
    output logic                  busy_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    typedef struct packed {
        logic              busy;
        logic              full;
        logic              commit;
        op_e               op;
        logic [PORT_W-1:0] port;
        logic [VID_W-1:0]  vid;
        logic [MASK_W-1:0] dmask;
        logic              dvalid;
        logic [IDX_W-1:0]  idx;
        logic              hit_seen;
        logic [IDX_W-1:0]  hit_idx;
        logic              free_seen;
        logic [IDX_W-1:0]  free_idx;
    } st_t;

    st_t       d, q;
    vlan_ent_t cur;
    logic      cmd_wr, dat_wr, vid_eq;

    assign cmd_wr = reg_wr && !reg_sel;
    assign dat_wr = reg_wr &&  reg_sel;
    assign cur    = tbl[q.idx];
    assign vid_eq = cur.valid && (cur.vid == q.vid);

    always_comb begin
        d      = q;
        wr_en  = 1'b0;
        wr_idx = q.idx;
        wr_ent = cur;
        if (!q.busy) begin
            if (dat_wr) begin
                d.dmask  = reg_wdata[MASK_W-1:0];
                d.dvalid = reg_wdata[DAT_VALID_BIT];
            end
            if (cmd_wr) begin
                d.op   = op_e'(reg_wdata[2:0]);
                d.port = reg_wdata[CMD_PORT_LSB +: PORT_W];
                d.vid  = reg_wdata[CMD_VID_LSB +: VID_W];
                if (reg_wdata[CMD_GO_BIT]) begin
                    d.busy      = 1'b1;
                    d.full      = 1'b0;
                    d.commit    = 1'b0;
                    d.idx       = '0;
                    d.hit_seen  = 1'b0;
                    d.free_seen = 1'b0;
                end
            end
        end else begin
            case (q.op)
                OP_FLUSH, OP_PURGE, OP_DROP_PORT: begin
                    if (q.op == OP_FLUSH) begin
                        wr_en        = 1'b1;
                        wr_ent.valid = 1'b0;
                    end else if (q.op == OP_PURGE) begin
                        wr_en        = vid_eq;
                        wr_ent.valid = 1'b0;
                    end else begin
                        wr_en       = cur.valid;
                        wr_ent.mask = cur.mask & ~(MASK_W'(1) << q.port);
                    end
                    if (q.idx == LAST) d.busy = 1'b0;
                    else               d.idx  = q.idx + 1'b1;
                end
                OP_LOAD: begin
                    if (!q.commit) begin
                        if (vid_eq && !q.hit_seen) begin
                            d.hit_seen = 1'b1;
                            d.hit_idx  = q.idx;
                        end
                        if (!cur.valid && !q.free_seen) begin
                            d.free_seen = 1'b1;
                            d.free_idx  = q.idx;
                        end
                        if (q.idx == LAST) d.commit = 1'b1;
                        else               d.idx    = q.idx + 1'b1;
                    end else begin
                        wr_ent.valid = q.dvalid;
                        wr_ent.vid   = q.vid;
                        wr_ent.mask  = q.dmask;
                        if (q.hit_seen) begin
                            wr_en  = 1'b1;
                            wr_idx = q.hit_idx;
                        end else if (q.free_seen) begin
                            wr_en  = 1'b1;
                            wr_idx = q.free_idx;
                        end else begin
                            d.full = 1'b1;
                        end
                        d.busy   = 1'b0;
                        d.commit = 1'b0;
                    end
                end
                default: d.busy = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_sel) begin
            reg_rdata[MASK_W-1:0]    = q.dmask;
            reg_rdata[DAT_VALID_BIT] = q.dvalid;
        end else begin
            reg_rdata[2:0]                      = q.op;
            reg_rdata[CMD_GO_BIT]               = q.busy;
            reg_rdata[CMD_FULL_BIT]             = q.full;
            reg_rdata[CMD_PORT_LSB +: PORT_W]   = q.port;
            reg_rdata[CMD_VID_LSB +: VID_W]     = q.vid;
        end
    end

    assign busy_o = q.busy;

    logic unused_wdata;
    assign unused_wdata = ^{reg_wdata[31:28], reg_wdata[15:12], reg_wdata[7:4], reg_wdata[10]};

    // R10: command fields stay locked while a command runs
    p_cmd_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy && cmd_wr |=> $stable(q.op) && $stable(q.vid) && $stable(q.port));

    // R10: staged data stays locked while a command runs
    p_data_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy && dat_wr |=> $stable(q.dmask) && $stable(q.dvalid));

    // R6: only a load can raise full
    p_full_from_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.full) |-> (q.op == OP_LOAD));

    // R12: a no-op finishes after one busy cycle
    p_nop_one_cycle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) && (q.op == OP_NOP) |=> !q.busy);
endmodule

// File: rtl/vlan_tbl_engine.sv
module vlan_tbl_engine
    import vlan_tbl_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [11:0] lk_vid,
    output logic        lk_hit,
    output logic [9:0]  lk_mask
);
    localparam int IDX_W = $clog2(DEPTH);

    vlan_ent_t [DEPTH-1:0] tbl;
    logic                  wr_en, busy;
    logic [IDX_W-1:0]      wr_idx;
    vlan_ent_t             wr_ent;

    vlan_tbl_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tbl(tbl),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_ent(wr_ent), .busy_o(busy)
    );

    vlan_tbl_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_ent(wr_ent), .tbl_o(tbl)
    );

    vlan_tbl_lookup #(.DEPTH(DEPTH)) u_lookup (
        .clk(clk), .rst_n(rst_n), .tbl(tbl), .q_vid(lk_vid),
        .hit(lk_hit), .mask(lk_mask)
    );

    // R3: the table only changes while a command runs
    p_idle_table_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(tbl));
endmodule

// File: tb/vlan_tbl_engine_test.sv
`timescale 1ns/1ps
module vlan_tbl_engine_test;
    localparam real CLK_NS = 8.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [11:0] lk_vid = '0;
    logic        lk_hit;
    logic [9:0]  lk_mask;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_NS / 2) clk = ~clk;

    vlan_tbl_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lk_vid(lk_vid), .lk_hit(lk_hit), .lk_mask(lk_mask)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [11:0] vid;
        logic [3:0]  port;
        logic [9:0]  mask;
        logic [11:0] qvid;
        logic        qhit;
        logic [9:0]  qmask;
    } vec_t;

    // op, vid, port, data mask, lookup vid, expected hit, expected mask
    localparam vec_t VECS [8] = '{
        '{3'd2, 12'd5,    4'd0, 10'h3FF, 12'd5,    1'b1, 10'h3FF}, // R4 fresh load
        '{3'd2, 12'd100,  4'd0, 10'h00F, 12'd100,  1'b1, 10'h00F}, // R4 second slot
        '{3'd2, 12'd5,    4'd0, 10'h0A0, 12'd5,    1'b1, 10'h0A0}, // R5 overwrite
        '{3'd4, 12'd0,    4'd1, 10'h000, 12'd100,  1'b1, 10'h00D}, // R8 drop port 1
        '{3'd3, 12'd5,    4'd0, 10'h000, 12'd5,    1'b0, 10'h000}, // R7 purge
        '{3'd0, 12'd0,    4'd0, 10'h000, 12'd100,  1'b1, 10'h00D}, // R7 other kept
        '{3'd2, 12'd4095, 4'd0, 10'h200, 12'd4095, 1'b1, 10'h200}, // R4 top vid
        '{3'd4, 12'd0,    4'd9, 10'h000, 12'd4095, 1'b1, 10'h000}  // R8 mask empties
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] data);
        @(negedge clk);
        reg_sel = sel; reg_wdata = data; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic logic [31:0] cmd_word(input logic [2:0] op, input logic go,
                                             input logic [3:0] port, input logic [11:0] vid);
        return {4'h0, vid, 4'h0, port, 4'h0, go, op};
    endfunction

    function automatic logic [31:0] dat_word(input logic [9:0] mask, input logic valid);
        return {20'h0, valid, 1'b0, mask};
    endfunction

    task automatic rd(input logic sel, output logic [31:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    // count busy cycles starting at the negedge right after the command write
    task automatic busy_len(output int n);
        logic [31:0] v;
        n = 0;
        rd(1'b0, v);
        while (v[3] && n < 100) begin
            n++;
            @(negedge clk);
            rd(1'b0, v);
        end
    endtask

    task automatic look(input logic [11:0] vid, output logic h, output logic [9:0] m);
        lk_vid = vid;
        #1;
        h = lk_hit;
        m = lk_mask;
    endtask

    task automatic load(input logic [11:0] vid, input logic [9:0] mask);
        int n;
        wr(1'b1, dat_word(mask, 1'b1));
        wr(1'b0, cmd_word(3'd2, 1'b1, 4'd0, vid));
        busy_len(n);
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic        h;
        logic [9:0]  m;
        int          n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, v); check("R1 command word after reset", v, 32'h0);
        rd(1'b1, v); check("R1 data word after reset", v, 32'h0);
        look(12'd0, h, m); check("R1 lookup vid 0 after reset", {h, m}, 11'h0);

        // main vector walk: R4 R5 R7 R8 R11
        for (int i = 0; i < 8; i++) begin
            if (VECS[i].op == 3'd2) wr(1'b1, dat_word(VECS[i].mask, 1'b1));
            wr(1'b0, cmd_word(VECS[i].op, 1'b1, VECS[i].port, VECS[i].vid));
            busy_len(n);
            look(VECS[i].qvid, h, m);
            check($sformatf("R4 R5 R7 R8 R11 vector %0d", i), {h, m}, {VECS[i].qhit, VECS[i].qmask});
        end
        look(12'd4094, h, m); check("R11 miss on absent vid", {h, m}, 11'h0);

        // R2 readback of data and command fields
        wr(1'b1, dat_word(10'h155, 1'b1));
        rd(1'b1, v); check("R2 data readback", v, 32'h0000_0955);
        wr(1'b0, cmd_word(3'd2, 1'b0, 4'd6, 12'd7));
        @(negedge clk);
        rd(1'b0, v); check("R2 R3 command stored without go", v, 32'h0007_0602);
        look(12'd7, h, m); check("R3 no start without go", {h, m}, 11'h0);

        // R12 no-op length
        wr(1'b0, cmd_word(3'd0, 1'b1, 4'd0, 12'd0));
        busy_len(n); check("R12 no-op busy cycles", n, 1);

        // R9 flush length and effect, R10 writes while busy
        wr(1'b1, dat_word(10'h011, 1'b1));
        wr(1'b0, cmd_word(3'd1, 1'b1, 4'd0, 12'd9));
        rd(1'b0, v); check("R3 busy reads 1 after start", v[3], 1'b1);
        @(negedge clk);
        reg_sel = 1'b1; reg_wdata = dat_word(10'h3EE, 1'b0); reg_wr = 1'b1;
        @(negedge clk);
        reg_sel = 1'b0; reg_wdata = cmd_word(3'd3, 1'b1, 4'd2, 12'd55);
        @(negedge clk);
        reg_wr = 1'b0;
        busy_len(n); check("R9 flush busy cycles", n + 3, 16);
        rd(1'b1, v); check("R10 data write ignored while busy", v, 32'h0000_0811);
        rd(1'b0, v); check("R10 command write ignored while busy", v, 32'h0009_0001);
        look(12'd100, h, m); check("R9 flush cleared vid 100", {h, m}, 11'h0);
        look(12'd4095, h, m); check("R9 flush cleared vid 4095", {h, m}, 11'h0);

        // R4 load length
        wr(1'b1, dat_word(10'h001, 1'b1));
        wr(1'b0, cmd_word(3'd2, 1'b1, 4'd0, 12'd1));
        busy_len(n); check("R4 load busy cycles", n, 17);

        // fill the table: vids 1..16
        for (int k = 2; k <= 16; k++) load(12'(k), 10'(k));
        rd(1'b0, v); check("R4 full clear with 16 entries", v[4], 1'b0);
        look(12'd16, h, m); check("R4 last slot filled", {h, m}, {1'b1, 10'd16});

        load(12'd1, 10'h3FF);
        rd(1'b0, v); check("R5 overwrite while full no full flag", v[4], 1'b0);
        look(12'd1, h, m); check("R5 overwrite while full", {h, m}, {1'b1, 10'h3FF});

        load(12'd17, 10'h0F0);
        rd(1'b0, v); check("R6 full raised", v[4], 1'b1);
        look(12'd17, h, m); check("R6 rejected vid absent", {h, m}, 11'h0);
        look(12'd8, h, m); check("R6 table unchanged", {h, m}, {1'b1, 10'd8});

        wr(1'b0, cmd_word(3'd0, 1'b1, 4'd0, 12'd0));
        busy_len(n);
        rd(1'b0, v); check("R6 full cleared by next command", v[4], 1'b0);

        // R8 remove port across many entries (vid 3 mask 0x003 -> 0x001)
        wr(1'b0, cmd_word(3'd4, 1'b1, 4'd1, 12'd0));
        busy_len(n); check("R8 remove busy cycles", n, 16);
        look(12'd3, h, m); check("R8 bit cleared in vid 3", {h, m}, {1'b1, 10'h001});
        look(12'd2, h, m); check("R8 mask emptied stays valid", {h, m}, {1'b1, 10'h000});

        // R1 reset again clears the table
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        look(12'd8, h, m); check("R1 reset clears filled table", {h, m}, 11'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule